// File: doc/BRIEF.md
# Reset-Time Boot Mode and Bus Clock Divider

This block decides, once per power-on reset, how the device comes up. While the power-on reset input is high, everything is held idle and the bus clock does not run. On the first oscillator edge after reset is released it samples two strap inputs and freezes them. The first is a flag from an external high-voltage detector on the interrupt pin, and it selects monitor mode or user mode. The second is a prescaler strap. Nothing the straps do afterwards has any effect until the next power-on reset.

The frozen selection sets the divider that turns the oscillator into the bus clock. In monitor mode with the prescaler strap low, one divide-by-two stage is bypassed, so the bus clock is the oscillator divided by two. Every other combination divides by four. As a result, a 4.9152 MHz oscillator with the strap low and a 9.8304 MHz oscillator with the strap high both give a 2.4576 MHz bus clock. The divider setting only changes under reset, so the bus clock cannot glitch while it runs.

In monitor mode the block also forces the watchdog off. It produces a baud tick every `BAUD_DIV` bus cycles, which is 9600 Hz from a 2.4576 MHz bus clock, for the single-pin serial link.

Top module: `boot_mode_clkgen`

## Requirements
- R1: While `por` is high, `bus_clk`, `mon_mode`, `wdog_off` and `baud_tick` are all 0.
- R2: The straps are sampled only on the first `osc_clk` rising edge after `por` goes low. Any later strap activity leaves every output unchanged until the next power-on reset.
- R3: `mon_mode` becomes 1 after that first edge when `irq_hv` was 1 at sampling, and 0 (user mode) otherwise.
- R4: In monitor mode with `strap_div` sampled 0, `bus_clk` has a period of 2 oscillator cycles, with one cycle high and one cycle low.
- R5: In monitor mode with `strap_div` sampled 1, `bus_clk` has a period of 4 oscillator cycles, with two cycles high and two cycles low.
- R6: In user mode, `bus_clk` has a period of 4 oscillator cycles (two high, two low) whatever `strap_div` was.
- R7: `wdog_off` is 1 exactly when monitor mode is latched.
- R8: In monitor mode, `baud_tick` is a one-oscillator-cycle pulse. It rises on the same edge as every `BAUD_DIV`-th rising edge of `bus_clk`, counting from the first. In user mode it stays 0.
- R9: The first rising edge of `bus_clk` comes on the second `osc_clk` edge after `por` is released. From then on the clock is high first in each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator input clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| irq_hv | input | 1 | High-voltage-detect flag on the interrupt pin (monitor request) |
| strap_div | input | 1 | Prescaler strap; 0 bypasses the divide-by-two stage in monitor mode |
| bus_clk | output | 1 | Divided bus clock |
| mon_mode | output | 1 | 1 = monitor mode latched, 0 = user mode |
| wdog_off | output | 1 | 1 = watchdog forced off |
| baud_tick | output | 1 | One-oscillator-cycle serial baud strobe |

## Verification
The bench applies all four strap combinations. After each release it compares every oscillator edge against a bus clock phase and tick position worked out arithmetically.

- Straps are toggled on every edge after sampling. A design that did not freeze them would change its divide ratio or mode part way through the run.
- User mode with the strap low is the case that catches a decoder which bypasses the divide-by-two stage without checking the mode. That design would run at half period.
- Checking the first rising edge and the exact tick edge catches off-by-one phase errors and a baud counter that counts from the wrong edge or at the wrong rate.

// File: rtl/boot_mode_pkg.sv
package boot_mode_pkg;

  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_MON  = 1'b1
  } op_mode_e;

  // True when the divide-by-two stage is skipped (bus = osc / 2).
  function automatic logic skip_half_stage(op_mode_e m, logic strap);
    return (m == MODE_MON) && !strap;
  endfunction

  // Last phase index of one bus period, counted in oscillator cycles.
  function automatic logic [1:0] bus_last_phase(logic short_div);
    return short_div ? 2'd1 : 2'd3;
  endfunction

  // Number of oscillator cycles the bus clock stays high per period.
  function automatic logic [1:0] bus_high_count(logic short_div);
    return short_div ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import boot_mode_pkg::*;
(
  input  logic     clk,
  input  logic     por,
  input  logic     hv_flag,
  input  logic     strap,
  output logic     locked,
  output op_mode_e mode,
  output logic     strap_q
);

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      locked  <= 1'b0;
      mode    <= MODE_USER;
      strap_q <= 1'b0;
    end else if (!locked) begin
      locked  <= 1'b1;
      mode    <= hv_flag ? MODE_MON : MODE_USER;
      strap_q <= strap;
    end
  end

  // R2: once frozen, the selection never moves before the next reset
  a_r2_frozen: assert property (@(posedge clk) disable iff (por)
    (locked && $past(locked)) |-> ($stable(mode) && $stable(strap_q)));

endmodule

// File: rtl/bus_clk_div.sv
module bus_clk_div
  import boot_mode_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic por,
  input  logic running,
  input  logic short_div,
  output logic bus_clk,
  output logic bus_rise
);

  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] ph_last;
  logic [PH_W-1:0] ph_high;

  assign ph_last  = PH_W'(bus_last_phase(short_div));
  assign ph_high  = PH_W'(bus_high_count(short_div));
  assign bus_rise = running && (ph == '0);

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      ph      <= '0;
      bus_clk <= 1'b0;
    end else if (running) begin
      ph      <= (ph == ph_last) ? '0 : ph + 1'b1;
      bus_clk <= (ph < ph_high);
    end
  end

  // R1: no bus clock before the selection is frozen
  a_r1_idle_low: assert property (@(posedge clk) disable iff (por)
    !running |-> !bus_clk);

  // R4: the short divider toggles the bus clock on every oscillator edge
  a_r4_toggle: assert property (@(posedge clk) disable iff (por)
    (running && $past(running) && short_div) |-> (bus_clk != $past(bus_clk)));

  // R5: the phase counter never leaves the selected period
  a_r5_phase_range: assert property (@(posedge clk) disable iff (por)
    running |-> (ph <= ph_last));

endmodule

// File: rtl/baud_strobe.sv
module baud_strobe #(
  parameter int BAUD_DIV = 256
) (
  input  logic clk,
  input  logic por,
  input  logic enable,
  input  logic bus_rise,
  output logic tick
);

  localparam int BAUD_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [BAUD_W-1:0] BAUD_LAST = BAUD_W'(BAUD_DIV - 1);

  logic [BAUD_W-1:0] bcnt;
  logic              wrap;

  assign wrap = enable && bus_rise && (bcnt == BAUD_LAST);

  always_ff @(posedge clk or posedge por) begin
    if (por) begin
      bcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      if (enable && bus_rise) bcnt <= wrap ? '0 : bcnt + 1'b1;
    end
  end

  // R8: user mode never strobes
  a_r8_user_silent: assert property (@(posedge clk) disable iff (por)
    !enable |-> !tick);

  // R8: strobe lasts exactly one oscillator cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (por)
    tick |=> !tick);

  // R8: strobe only follows a bus rising edge
  a_r8_on_rise: assert property (@(posedge clk) disable iff (por)
    tick |-> $past(bus_rise));

endmodule

// File: rtl/boot_mode_clkgen.sv
module boot_mode_clkgen
  import boot_mode_pkg::*;
#(
  parameter int BAUD_DIV = 256
) (
  input  logic osc_clk,
  input  logic por,
  input  logic irq_hv,
  input  logic strap_div,
  output logic bus_clk,
  output logic mon_mode,
  output logic wdog_off,
  output logic baud_tick
);

  logic     locked;
  op_mode_e mode;
  logic     strap_q;
  logic     short_div;
  logic     bus_rise;

  strap_latch u_latch (
    .clk     (osc_clk),
    .por     (por),
    .hv_flag (irq_hv),
    .strap   (strap_div),
    .locked  (locked),
    .mode    (mode),
    .strap_q (strap_q)
  );

  assign short_div = skip_half_stage(mode, strap_q);
  assign mon_mode  = (mode == MODE_MON);
  assign wdog_off  = mon_mode;

  bus_clk_div #(.PH_W(2)) u_div (
    .clk       (osc_clk),
    .por       (por),
    .running   (locked),
    .short_div (short_div),
    .bus_clk   (bus_clk),
    .bus_rise  (bus_rise)
  );

  baud_strobe #(.BAUD_DIV(BAUD_DIV)) u_baud (
    .clk      (osc_clk),
    .por      (por),
    .enable   (mon_mode),
    .bus_rise (bus_rise),
    .tick     (baud_tick)
  );

  // R6: user mode never takes the short divider
  a_r6_user_long: assert property (@(posedge osc_clk) disable iff (por)
    !mon_mode |-> !short_div);

  // R7: watchdog disable tracks the latched monitor mode
  a_r7_wdog: assert property (@(posedge osc_clk) disable iff (por)
    wdog_off |-> (locked && mode == MODE_MON));

endmodule

// File: tb/boot_mode_clkgen_test.sv
`timescale 1ns/1ps
module boot_mode_clkgen_test;

  localparam int BAUD = 256;

  logic osc_clk = 1'b0;
  logic por = 1'b1;
  logic irq_hv = 1'b0;
  logic strap_div = 1'b0;
  logic bus_clk, mon_mode, wdog_off, baud_tick;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 osc_clk = ~osc_clk;

  boot_mode_clkgen #(.BAUD_DIV(BAUD)) uut (
    .osc_clk   (osc_clk),
    .por       (por),
    .irq_hv    (irq_hv),
    .strap_div (strap_div),
    .bus_clk   (bus_clk),
    .mon_mode  (mon_mode),
    .wdog_off  (wdog_off),
    .baud_tick (baud_tick)
  );

  task automatic chk(input string req, input int edge_n, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s edge %0d: actual %0d expected %0d", req, edge_n, act, exp);
    end
  endtask

  task automatic run_case(input logic hv, input logic pre);
    int div;
    int nedges;
    bit mon;
    por = 1'b1;
    irq_hv = hv;
    strap_div = pre;
    repeat (3) @(posedge osc_clk);
    @(negedge osc_clk);
    // R1: everything idle under reset
    chk("R1 bus_clk", 0, int'(bus_clk), 0);
    chk("R1 mon_mode", 0, int'(mon_mode), 0);
    chk("R1 wdog_off", 0, int'(wdog_off), 0);
    chk("R1 baud_tick", 0, int'(baud_tick), 0);
    por = 1'b0;
    mon = hv;
    div = (mon && !pre) ? 2 : 4;
    nedges = 2 + 2 * BAUD * div + 3;
    for (int k = 1; k <= nedges; k++) begin
      int exp_bus;
      int exp_tick;
      @(posedge osc_clk);
      #1;
      if (k >= 2) exp_bus = (((k - 2) % div) < (div / 2)) ? 1 : 0;
      else        exp_bus = 0;
      exp_tick = 0;
      if (mon && k >= 2 && ((k - 2) % div) == 0 && ((((k - 2) / div) + 1) % BAUD) == 0)
        exp_tick = 1;
      if (k <= 3)
        chk("R9 first rise", k, int'(bus_clk), exp_bus);
      else if (!mon)
        chk("R6 user period", k, int'(bus_clk), exp_bus);
      else if (!pre)
        chk("R4 monitor div2", k, int'(bus_clk), exp_bus);
      else
        chk("R5 monitor div4", k, int'(bus_clk), exp_bus);
      chk("R3 mode", k, int'(mon_mode), int'(mon));
      chk("R7 wdog", k, int'(wdog_off), int'(mon));
      chk("R8 tick", k, int'(baud_tick), exp_tick);
      // R2: wiggle straps after sampling; outputs must not react
      #2;
      irq_hv = ~irq_hv;
      strap_div = (k % 3 == 0) ? ~strap_div : strap_div;
    end
    por = 1'b1;
  endtask

  initial begin
    run_case(1'b1, 1'b0);
    run_case(1'b1, 1'b1);
    run_case(1'b0, 1'b0);
    run_case(1'b0, 1'b1);
    // R2: a second release re-samples fresh straps
    run_case(1'b1, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule